// File: doc/BRIEF.md
# Programmable UART Baud Tick Generator

This block turns a fixed 1.8432 MHz reference clock into the two timing strobes that a UART transmitter and receiver run on. The first is a 16x oversampling strobe. The second is a one-bit-time strobe. The rate comes from a 16-bit divisor. A host writes the divisor one byte at a time through a shared 8-bit data bus, using an upper-byte write strobe and a lower-byte write strobe. The baud rate is the reference clock divided by sixteen times the divisor. Some examples: divisor 12 gives 9600 baud, divisor 1 gives 115200 baud, divisor 1047 gives 110 baud and divisor 1536 gives 75 baud.

A divisor of zero does not stop the counter and does not wrap it. It selects a fast mode at 230400 baud, which is twice the divide-by-one rate. In this mode the oversampling strobe is high on every clock and a bit spans 8 reference clocks instead of 16 strobes. Every latch write restarts the timing from a clean phase. A rate change therefore never produces a shortened strobe period.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 000Ch. With cycles counted from 0 at the first clock after reset is released, the first 16x strobe comes in cycle 11 and the first bit strobe comes in cycle 191.
- R2: For a divisor N of 1 or more, the 16x strobe is high exactly in the cycles where (cycles since the last reload) mod N equals N-1. With N = 1 the strobe is high on every cycle.
- R3: For a divisor N of 1 or more, the bit strobe is high exactly where (cycles since reload) mod 16N equals 16N-1. It is only ever high in a cycle where the 16x strobe is also high.
- R4: With divisor 0, the 16x strobe is high on every cycle and the bit strobe is high where (cycles since reload) mod 8 equals 7.
- R5: A write on the upper strobe loads data bits 7:0 into divisor bits 15:8. A write on the lower strobe loads them into divisor bits 7:0. A byte that is not written keeps its value. Both strobes may be given in the same cycle, and then the same data byte goes to both halves.
- R6: Any latch write restarts both counters at that clock edge, even when the written value does not change the divisor. The cycle after the write counts as cycle 0.
- R7: In the cycle after a write, the 16x strobe is low unless the new divisor is 0 or 1. A rate change never produces a shortened strobe period.
- R8: Divisor 1047 (upper 04h, lower 17h) gives a bit every 16752 clocks. Divisor 1536 (upper 06h, lower 00h) gives a bit every 24576 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 1.8432 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_data_i | input | 8 | Byte to load into a divisor latch |
| wr_msb_i | input | 1 | Write strobe for divisor bits 15:8 |
| wr_lsb_i | input | 1 | Write strobe for divisor bits 7:0 |
| tick16_o | output | 1 | 16x oversampling strobe, one cycle wide |
| bit_tick_o | output | 1 | One-bit-time strobe, one cycle wide |

## Verification
The bench sweeps every divisor from 0 to 20 and also runs the slowest documented rates. It targets the places where an off-by-one would show:
- A divider that counted N+1 states, or that let divisor 1 stall, would move every strobe away from its cycle mod N slot.
- A design that treated zero as 65536, or that kept 16 phases in fast mode, would miss the every-cycle strobe and the 8-clock bit.
- The bench rewrites the latch in the middle of a period, including with an unchanged value. A design that failed to restart would emit an early, short strobe after the write.
- The bench also does single-byte writes and a simultaneous two-byte write. A design that corrupted the untouched byte would drift to the wrong period.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // 16x strobe is due when the prescaler sits on its last state; 0 and 1 run every cycle
  function automatic logic tick_due(input int unsigned cnt, input int unsigned div);
    return (div <= 32'd1) || (cnt == div - 32'd1);
  endfunction

  // last oversampling phase of a bit: fast mode uses fewer phases
  function automatic int unsigned phase_last(input logic fast, input int unsigned ovs,
                                             input int unsigned fast_ovs);
    return fast ? fast_ovs - 32'd1 : ovs - 32'd1;
  endfunction

  // reference clocks per bit, for documentation of the arithmetic
  function automatic int unsigned bit_clocks(input int unsigned div, input int unsigned ovs,
                                             input int unsigned fast_ovs);
    return (div == 32'd0) ? fast_ovs : ovs * div;
  endfunction

endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int BYTE_W    = 8,
  parameter int NB        = 2,
  parameter int RESET_DIV = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BYTE_W-1:0]    wr_data_i,
  input  logic [NB-1:0]        wr_sel_i,
  output logic [NB*BYTE_W-1:0] div_o,
  output logic                 reload_o
);
  localparam int DIV_W = NB * BYTE_W;
  localparam logic [DIV_W-1:0] RST_V = DIV_W'(RESET_DIV);

  logic [BYTE_W-1:0] byte_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          byte_q[g] <= RST_V[g*BYTE_W +: BYTE_W];
      else if (wr_sel_i[g]) byte_q[g] <= wr_data_i;
    end
    assign div_o[g*BYTE_W +: BYTE_W] = byte_q[g];
  end

  assign reload_o = |wr_sel_i;
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             reload_i,
  output logic             tick_o,
  output logic             fast_o
);
  import baud_pkg::*;

  logic [DIV_W-1:0] cnt_q;

  assign fast_o = (div_i == '0);
  assign tick_o = tick_due(32'(cnt_q), 32'(div_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (reload_i) cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_phase.sv
module baud_phase #(
  parameter int OVS      = 16,
  parameter int FAST_OVS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fast_i,
  input  logic reload_i,
  output logic bit_o
);
  import baud_pkg::*;

  localparam int PH_W = $clog2(OVS);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] last_ph;

  assign last_ph = PH_W'(phase_last(fast_i, OVS, FAST_OVS));
  assign bit_o   = tick_i && (ph_q == last_ph);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= '0;
    else if (reload_i) ph_q <= '0;
    else if (bit_o)    ph_q <= '0;
    else if (tick_i)   ph_q <= ph_q + PH_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int BYTE_W    = 8,
  parameter int RESET_DIV = 12,
  parameter int OVS       = 16,
  parameter int FAST_OVS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_msb_i,
  input  logic              wr_lsb_i,
  output logic              tick16_o,
  output logic              bit_tick_o
);
  localparam int NB    = 2;
  localparam int DIV_W = NB * BYTE_W;

  // named internal events
  logic [DIV_W-1:0] div_q;
  logic             reload;
  logic             fast_mode;
  logic             tick16;
  logic             bit_tick;

  baud_div_latch #(.BYTE_W(BYTE_W), .NB(NB), .RESET_DIV(RESET_DIV)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_data_i(wr_data_i),
    .wr_sel_i ({wr_msb_i, wr_lsb_i}),
    .div_o    (div_q),
    .reload_o (reload)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_q),
    .reload_i(reload),
    .tick_o  (tick16),
    .fast_o  (fast_mode)
  );

  baud_phase #(.OVS(OVS), .FAST_OVS(FAST_OVS)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick16),
    .fast_i  (fast_mode),
    .reload_i(reload),
    .bit_o   (bit_tick)
  );

  assign tick16_o   = tick16;
  assign bit_tick_o = bit_tick;
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int BYTE_W    = 8,
  parameter int RESET_DIV = 12,
  parameter int OVS       = 16,
  parameter int FAST_OVS  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              wr_msb_i,
  input logic              wr_lsb_i,
  input logic              tick16_o,
  input logic              bit_tick_o
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int TW    = $clog2(OVS) + 1;

  logic [DIV_W-1:0] shadow_q;
  logic [DIV_W-1:0] gap_q;
  logic [TW-1:0]    tcnt_q;
  logic             wr_any;

  assign wr_any = wr_msb_i || wr_lsb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= DIV_W'(RESET_DIV);
    end else begin
      if (wr_msb_i) shadow_q[DIV_W-1:BYTE_W] <= wr_data_i;
      if (wr_lsb_i) shadow_q[BYTE_W-1:0]     <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gap_q <= '0;
    else if (wr_any)   gap_q <= '0;
    else if (tick16_o) gap_q <= '0;
    else               gap_q <= gap_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tcnt_q <= '0;
    else if (wr_any)     tcnt_q <= '0;
    else if (bit_tick_o) tcnt_q <= '0;
    else if (tick16_o)   tcnt_q <= tcnt_q + TW'(1);
  end

  // R3
  bit_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> tick16_o);

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && shadow_q > DIV_W'(1)) |-> (gap_q == shadow_q - DIV_W'(1)));

  // R2
  no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_q != '0) |-> (gap_q < shadow_q));

  // R4
  fast_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_q == '0) |-> tick16_o);

  // R7
  no_glitch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> (shadow_q <= DIV_W'(1) || !tick16_o));

  // R4
  bit_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> (tcnt_q == ((shadow_q == '0) ? TW'(FAST_OVS - 1) : TW'(OVS - 1))));
endmodule

bind baud_tick_gen baud_tick_chk #(
  .BYTE_W(BYTE_W), .RESET_DIV(RESET_DIV), .OVS(OVS), .FAST_OVS(FAST_OVS)
) u_chk (.*);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wd = 8'h00;
  logic       wm = 1'b0;
  logic       wl = 1'b0;
  logic       tick16;
  logic       bit_tick;

  int total = 0;
  int bad   = 0;
  int model_div = 12;
  int cyc = 0;
  bit just_wrote = 1'b0;
  string sec_tag = "";

  always #2 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_data_i(wd), .wr_msb_i(wm), .wr_lsb_i(wl),
    .tick16_o(tick16), .bit_tick_o(bit_tick)
  );

  function automatic logic exp_tick(input int d, input int c);
    if (d <= 1) return 1'b1;
    return (c % d) == d - 1;
  endfunction

  function automatic logic exp_bit(input int d, input int c);
    int per;
    per = (d == 0) ? 8 : 16 * d;
    return (c % per) == per - 1;
  endfunction

  task automatic check_now();
    logic et, eb;
    string tt, bt;
    et = exp_tick(model_div, cyc);
    eb = exp_bit(model_div, cyc);
    tt = (model_div == 0) ? "R4" : (just_wrote ? "R7" : "R2");
    bt = (model_div == 0) ? "R4" : "R3";
    if (sec_tag != "") begin tt = sec_tag; bt = sec_tag; end
    total += 2;
    if (tick16 !== et) begin
      bad++;
      $display("FAIL %s tick16 div=%0d cyc=%0d actual=%b expected=%b", tt, model_div, cyc, tick16, et);
    end
    if (bit_tick !== eb) begin
      bad++;
      $display("FAIL %s bit_tick div=%0d cyc=%0d actual=%b expected=%b", bt, model_div, cyc, bit_tick, eb);
    end
  endtask

  // check the current cycle, drive inputs for the next edge, advance the model
  task automatic step(input logic m, input logic l, input logic [7:0] d);
    check_now();
    wm = m; wl = l; wd = d;
    @(negedge clk);
    if (m) model_div = (model_div & 32'h00FF) | (int'(d) << 8);
    if (l) model_div = (model_div & 32'hFF00) | int'(d);
    just_wrote = m | l;
    cyc = (m | l) ? 0 : cyc + 1;
    wm = 1'b0; wl = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic set_div(input int v);
    step(1'b1, 1'b0, v[15:8]);
    step(1'b0, 1'b1, v[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; model_div = 12;

    // R1: default divisor 12, first strobes at cycles 11 and 191
    sec_tag = "R1";
    idle(2 * 192 + 5);
    sec_tag = "";

    // R2 R3 R4 R7: sweep small divisors including the zero fast mode
    for (int n = 0; n <= 20; n++) begin
      set_div(n);
      idle(2 * ((n == 0) ? 8 : 16 * n) + 3);
    end

    // R8: slow documented rates
    sec_tag = "R8";
    set_div(1047);
    idle(16752 + 20);
    set_div(1536);
    idle(24576 + 20);

    // R6: rewrite mid-period with an unchanged value restarts the timing
    sec_tag = "R6";
    set_div(5);
    idle(37);
    step(1'b0, 1'b1, 8'h05);
    idle(200);

    // R5: simultaneous write and single-byte writes keep the other byte
    sec_tag = "R5";
    step(1'b1, 1'b1, 8'h00);
    idle(20);
    step(1'b1, 1'b0, 8'h01);
    idle(4096 + 10);
    step(1'b0, 1'b1, 8'h03);
    idle(16 * 259 + 10);
    step(1'b1, 1'b1, 8'h01);
    idle(16 * 257 + 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule